// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter for a small processor subsystem, reached through a simple register bus. After configuration, software must prove it is alive by writing a service key while the counter is inside an allowed window. If the counter reaches the programmed limit with no service, or software services too early or with a wrong key, the block raises its fault action. The fault action is either a non-maskable interrupt that stays high until software acknowledges it, or a fixed-length reset pulse. A second fault while the interrupt is still pending always escalates to the reset pulse.

The limit, window and control registers are protected: a write to them takes effect only directly after a two-step key sequence, and the first control write that enables watchdog mode locks the enable on until the next reset. The same counter can instead run as a periodic timer that sets a maskable interrupt flag on each period and never faults. Two synchronous resets are provided. `por_i` is a cold reset that clears everything. `rst_i` is a warm reset, typically driven from the block's own reset pulse, and it keeps the record of the last fault cause.

Top module: `wwd_top`

## Requirements
- R1: After reset the control register (address 1) reads 3'b011 (bit0 enable = 1, bit1 reset action = 1, bit2 timer mode = 0), the limit register (address 2) reads 0xFFFF, the window register (address 3) reads 0, the status register (address 5) reads 0, and all three outputs are low.
- R2: A write to address 1, 2 or 3 takes effect only if the two bus writes just before it were 0x5555 and then 0xAAAA to address 0. Any other write in between cancels the sequence, and one applied write uses it up. An applied write also reloads the counter to 0.
- R3: With the block enabled and no service, the fault occurs on the T+1-th clock edge after the counter was last reloaded, where T is the limit value.
- R4: Writing 0xA5A5 to address 4 while the counter (readable at address 6) is at or above the window value reloads the counter to 0 and raises no fault.
- R5: Writing 0xA5A5 to address 4 while the counter is below the window value is a fault, and it records cause 2 in status bits [3:2].
- R6: Writing any value other than 0xA5A5 to address 4 in watchdog mode is a fault, and it records cause 3. A timeout records cause 1.
- R7: On a fault, control bit1 = 0 selects `nmi_o` and bit1 = 1 selects `sys_rst_o`.
- R8: `nmi_o` stays high until software writes 1 to status bit0. A fault that occurs while `nmi_o` is high produces the reset pulse.
- R9: `sys_rst_o` is high for exactly 16 consecutive clock cycles per fault.
- R10: After a control write applies enable = 1 with timer mode = 0, later control writes cannot clear the enable or set timer mode until reset.
- R11: With control = 3'b101 (timer mode), every T+1 edges the counter reloads and `tmr_irq_o` (status bit1) is set. The flag is cleared by writing 1 to status bit1. No fault ever occurs in this mode, and writes to address 4 are ignored.
- R12: The status cause field survives `rst_i` and is cleared only by `por_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Cold synchronous reset, clears everything |
| rst_i | input | 1 | Warm synchronous reset, keeps the fault cause |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable qualifying bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| nmi_o | output | 1 | Non-maskable interrupt, held until acknowledged |
| sys_rst_o | output | 1 | System reset pulse |
| tmr_irq_o | output | 1 | Periodic timer interrupt flag |

## Verification
The bench measures the exact edge count from a reload to the fault. A counter that compares off by one, or misses the reload on a configuration write, shows up there as T or T+2. Randomised window trials service at every distance from the reload, so a window test with the wrong direction or a strict comparison flags valid kicks or lets early ones pass. Directed cases check the key sequence broken by a foreign write, the one-shot unlock, the locked enable, escalation of a fault with a pending NMI into a 16-cycle reset pulse, and the cause field across a warm reset. A design that leaked a timer-mode service write or lost the cause on `rst_i` would show it in status readback.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
    localparam int DW = 16;
    localparam int AW = 3;

    localparam logic [DW-1:0] UNLOCK_A = 16'h5555;
    localparam logic [DW-1:0] UNLOCK_B = 16'hAAAA;
    localparam logic [DW-1:0] SVC_KEY  = 16'hA5A5;

    localparam logic [AW-1:0] A_KEY  = 3'd0;
    localparam logic [AW-1:0] A_CTRL = 3'd1;
    localparam logic [AW-1:0] A_TMO  = 3'd2;
    localparam logic [AW-1:0] A_WIN  = 3'd3;
    localparam logic [AW-1:0] A_SVC  = 3'd4;
    localparam logic [AW-1:0] A_STAT = 3'd5;
    localparam logic [AW-1:0] A_CNT  = 3'd6;

    typedef enum logic [1:0] {CS_NONE, CS_TIMEOUT, CS_EARLY, CS_BADKEY} cause_e;
    typedef enum logic [1:0] {KS_IDLE, KS_HALF, KS_OPEN} key_e;

    typedef struct packed {
        logic tmr_mode;
        logic act_rst;
        logic en;
    } ctrl_t;

    typedef struct packed {
        ctrl_t           ctrl;
        logic [DW-1:0]   tmo;
        logic [DW-1:0]   win;
    } cfg_t;

    localparam ctrl_t CTRL_RESET = '{tmr_mode: 1'b0, act_rst: 1'b1, en: 1'b1};

    function automatic logic is_cfg_addr(input logic [AW-1:0] a);
        return (a == A_CTRL) || (a == A_TMO) || (a == A_WIN);
    endfunction
endpackage

// File: rtl/wwd_regs.sv
module wwd_regs
    import wwd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic           nmi,
    input  logic           irq,
    input  cause_e         cause,
    input  logic [DW-1:0]  cnt,
    output cfg_t           cfg,
    output logic           cfg_load,
    output logic           svc_wr,
    output logic [DW-1:0]  svc_data,
    output logic           clr_nmi,
    output logic           clr_irq
);
    key_e  key_q;
    cfg_t  cfg_q;
    logic  commit_q;
    logic  wr;
    ctrl_t ctrl_new;

    assign wr       = bus_sel && bus_we;
    assign cfg_load = wr && is_cfg_addr(bus_addr) && (key_q == KS_OPEN);
    assign svc_wr   = wr && (bus_addr == A_SVC);
    assign svc_data = bus_wdata;
    assign clr_nmi  = wr && (bus_addr == A_STAT) && bus_wdata[0];
    assign clr_irq  = wr && (bus_addr == A_STAT) && bus_wdata[1];
    assign cfg      = cfg_q;

    // control value after applying the commit lock
    always_comb begin
        ctrl_new = ctrl_t'(bus_wdata[2:0]);
        if (commit_q) begin
            ctrl_new.en       = 1'b1;
            ctrl_new.tmr_mode = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= KS_IDLE;
        end else if (wr) begin
            if (bus_addr == A_KEY && bus_wdata == UNLOCK_A)
                key_q <= KS_HALF;
            else if (bus_addr == A_KEY && bus_wdata == UNLOCK_B && key_q == KS_HALF)
                key_q <= KS_OPEN;
            else
                key_q <= KS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.ctrl <= CTRL_RESET;
            cfg_q.tmo  <= '1;
            cfg_q.win  <= '0;
            commit_q   <= 1'b0;
        end else if (cfg_load) begin
            case (bus_addr)
                A_CTRL: begin
                    cfg_q.ctrl <= ctrl_new;
                    if (ctrl_new.en && !ctrl_new.tmr_mode)
                        commit_q <= 1'b1;
                end
                A_TMO:   cfg_q.tmo <= bus_wdata;
                A_WIN:   cfg_q.win <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = {{(DW-3){1'b0}}, cfg_q.ctrl};
            A_TMO:  bus_rdata = cfg_q.tmo;
            A_WIN:  bus_rdata = cfg_q.win;
            A_STAT: bus_rdata = {{(DW-4){1'b0}}, cause, irq, nmi};
            A_CNT:  bus_rdata = cnt;
            default: bus_rdata = '0;
        endcase
    end

    // R2: protected registers do not move without an open key sequence
    assert_locked_cfg_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && is_cfg_addr(bus_addr) && key_q != KS_OPEN) |=> $stable(cfg_q));

    // R10: once committed the watchdog stays enabled in watchdog mode
    assert_commit_hold_R10: assert property (@(posedge clk) disable iff (rst)
        commit_q |=> (cfg_q.ctrl.en && !cfg_q.ctrl.tmr_mode));
endmodule

// File: rtl/wwd_core.sv
module wwd_core
    import wwd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           tmr_mode,
    input  logic [DW-1:0]  tmo,
    input  logic [DW-1:0]  win,
    input  logic           cfg_load,
    input  logic           svc_wr,
    input  logic [DW-1:0]  svc_data,
    output logic [DW-1:0]  cnt,
    output logic           fault,
    output cause_e         fault_cause,
    output logic           tick
);
    logic [DW-1:0] cnt_q;
    logic wd_on, key_ok, kick_ok, kick_early, kick_bad, hit;

    assign wd_on      = en && !tmr_mode;
    assign key_ok     = (svc_data == SVC_KEY);
    assign kick_ok    = svc_wr && wd_on && key_ok && (cnt_q >= win);
    assign kick_early = svc_wr && wd_on && key_ok && (cnt_q < win);
    assign kick_bad   = svc_wr && wd_on && !key_ok;
    assign hit        = en && (cnt_q >= tmo);
    assign cnt        = cnt_q;

    // priority: bad key, early kick, valid kick, limit reached
    always_comb begin
        fault       = 1'b0;
        fault_cause = CS_NONE;
        tick        = 1'b0;
        if (kick_bad) begin
            fault       = 1'b1;
            fault_cause = CS_BADKEY;
        end else if (kick_early) begin
            fault       = 1'b1;
            fault_cause = CS_EARLY;
        end else if (!kick_ok && hit) begin
            if (wd_on) begin
                fault       = 1'b1;
                fault_cause = CS_TIMEOUT;
            end else begin
                tick = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!en || cfg_load || kick_ok || fault || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R4: a valid service restarts the count
    assert_kick_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (kick_ok && !cfg_load) |=> (cnt_q == '0));

    // R11: timer period end reloads the counter
    assert_tmr_reload_R11: assert property (@(posedge clk) disable iff (rst)
        (en && tmr_mode && cnt_q >= tmo) |=> (cnt_q == '0));

    // R3: the counter never runs past the limit while enabled
    assert_no_overrun_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !cfg_load && cnt_q < tmo && !$isunknown(tmo)) |=> (cnt_q <= $past(tmo)));
endmodule

// File: rtl/wwd_action.sv
module wwd_action
    import wwd_pkg::*;
#(
    parameter int RST_CYC = 16
) (
    input  logic    clk,
    input  logic    por,
    input  logic    rst,
    input  logic    act_rst,
    input  logic    fault,
    input  cause_e  fault_cause,
    input  logic    tick,
    input  logic    clr_nmi,
    input  logic    clr_irq,
    output logic    nmi,
    output logic    irq,
    output logic    rst_pulse,
    output cause_e  cause
);
    localparam int PW = $clog2(RST_CYC + 1);

    logic          nmi_q, irq_q;
    logic [PW-1:0] pcnt_q;
    cause_e        cause_q;
    logic          f, go_rst;

    assign f         = fault && !rst;
    assign go_rst    = f && (act_rst || nmi_q);
    assign nmi       = nmi_q;
    assign irq       = irq_q;
    assign rst_pulse = (pcnt_q != '0);
    assign cause     = cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (f && !act_rst && !nmi_q)
                nmi_q <= 1'b1;
            else if (clr_nmi)
                nmi_q <= 1'b0;
            if (tick)
                irq_q <= 1'b1;
            else if (clr_irq)
                irq_q <= 1'b0;
        end
    end

    // pulse and cause live in the cold reset domain
    always_ff @(posedge clk) begin
        if (por) begin
            pcnt_q  <= '0;
            cause_q <= CS_NONE;
        end else begin
            if (go_rst && pcnt_q == '0)
                pcnt_q <= PW'(RST_CYC);
            else if (pcnt_q != '0)
                pcnt_q <= pcnt_q - 1'b1;
            if (f)
                cause_q <= fault_cause;
        end
    end

    // checker: length of the current high run of the reset output
    logic [PW:0] hi_len;
    always_ff @(posedge clk) begin
        if (por)
            hi_len <= '0;
        else if (rst_pulse)
            hi_len <= hi_len + 1'b1;
        else
            hi_len <= '0;
    end

    // R9: pulse never exceeds and always reaches its length
    assert_pulse_max_R9: assert property (@(posedge clk) disable iff (por)
        rst_pulse |-> (hi_len < (PW+1)'(RST_CYC)));
    assert_pulse_full_R9: assert property (@(posedge clk) disable iff (por)
        (!rst_pulse && hi_len != '0) |-> (hi_len == (PW+1)'(RST_CYC)));

    // R8: NMI held until acknowledged
    assert_nmi_hold_R8: assert property (@(posedge clk) disable iff (rst || por)
        (nmi_q && !clr_nmi) |=> nmi_q);

    // R12: warm reset leaves the cause record alone
    assert_cause_keep_R12: assert property (@(posedge clk) disable iff (por)
        rst |=> $stable(cause_q));

    // R5: an early kick is recorded as such
    assert_early_rec_R5: assert property (@(posedge clk) disable iff (por || rst)
        (fault && fault_cause == CS_EARLY) |=> (cause_q == CS_EARLY));
endmodule

// File: rtl/wwd_top.sv
module wwd_top
    import wwd_pkg::*;
#(
    parameter int RST_CYC = 16
) (
    input  logic           clk,
    input  logic           por_i,
    input  logic           rst_i,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           nmi_o,
    output logic           sys_rst_o,
    output logic           tmr_irq_o
);
    logic          wrst;
    cfg_t          cfg;
    logic          cfg_load, svc_wr, clr_nmi, clr_irq;
    logic [DW-1:0] svc_data, cnt;
    logic          fault, tick;
    cause_e        fault_cause, cause;

    assign wrst = rst_i || por_i;

    wwd_regs u_regs (
        .clk(clk), .rst(wrst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nmi(nmi_o), .irq(tmr_irq_o), .cause(cause), .cnt(cnt),
        .cfg(cfg), .cfg_load(cfg_load), .svc_wr(svc_wr), .svc_data(svc_data),
        .clr_nmi(clr_nmi), .clr_irq(clr_irq)
    );

    wwd_core u_core (
        .clk(clk), .rst(wrst),
        .en(cfg.ctrl.en), .tmr_mode(cfg.ctrl.tmr_mode),
        .tmo(cfg.tmo), .win(cfg.win),
        .cfg_load(cfg_load), .svc_wr(svc_wr), .svc_data(svc_data),
        .cnt(cnt), .fault(fault), .fault_cause(fault_cause), .tick(tick)
    );

    wwd_action #(.RST_CYC(RST_CYC)) u_action (
        .clk(clk), .por(por_i), .rst(wrst),
        .act_rst(cfg.ctrl.act_rst),
        .fault(fault), .fault_cause(fault_cause), .tick(tick),
        .clr_nmi(clr_nmi), .clr_irq(clr_irq),
        .nmi(nmi_o), .irq(tmr_irq_o), .rst_pulse(sys_rst_o), .cause(cause)
    );
endmodule

// File: tb/test_wwd_top.sv
module test_wwd_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por = 1'b1, rst = 1'b1;
    logic        sel = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        nmi, srst, irq;

    int n_chk = 0, n_fail = 0;
    logic [15:0] v;
    int n;

    always #(CLK_PERIOD/2) clk = ~clk;

    wwd_top i_wwd_top (
        .clk(clk), .por_i(por), .rst_i(rst),
        .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata),
        .nmi_o(nmi), .sys_rst_o(srst), .tmr_irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int t);
        return t + 1;
    endfunction

    function automatic bit exp_early(input int d, input int w);
        return d < w;
    endfunction

    function automatic int stat_word(input int cause, input int ir, input int nm);
        return cause * 4 + ir * 2 + nm;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic cfgw(input logic [2:0] a, input logic [15:0] d);
        wr(3'd0, 16'h5555);
        wr(3'd0, 16'hAAAA);
        wr(a, d);
    endtask

    task automatic do_por();
        por = 1'b1; rst = 1'b1;
        repeat (3) @(posedge clk);
        #1; por = 1'b0; rst = 1'b0;
    endtask

    function automatic logic pick(input int which);
        case (which)
            0: return nmi;
            1: return srst;
            2: return irq;
            default: return !srst;
        endcase
    endfunction

    task automatic edges_until(input int which, input int lim, output int cnt_e);
        cnt_e = 0;
        do begin
            @(posedge clk); #1;
            cnt_e++;
        end while (!pick(which) && cnt_e < lim);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_por();

        // R1 reset state
        rd(3'd1, v); chk("R1 ctrl", v, 3);
        rd(3'd2, v); chk("R1 limit", v, 16'hFFFF);
        rd(3'd3, v); chk("R1 window", v, 0);
        rd(3'd5, v); chk("R1 status", v, 0);
        chk("R1 outputs", {nmi, srst, irq}, 0);

        // R2 locked, cancelled, opened, one-shot
        wr(3'd2, 16'd50);
        rd(3'd2, v); chk("R2 no unlock", v, 16'hFFFF);
        wr(3'd0, 16'h5555); wr(3'd5, 16'h0000); wr(3'd0, 16'hAAAA); wr(3'd3, 16'd7);
        rd(3'd3, v); chk("R2 cancelled", v, 0);
        cfgw(3'd3, 16'd7);
        rd(3'd3, v); chk("R2 opened", v, 7);
        wr(3'd3, 16'd9);
        rd(3'd3, v); chk("R2 one shot", v, 7);

        // R11 timer mode
        do_por();
        cfgw(3'd2, 16'd30);
        cfgw(3'd1, 16'd5);
        edges_until(2, 200, n); chk("R11 period", n, exp_period(30));
        wr(3'd4, 16'h1234);
        chk("R11 svc ignored nmi", nmi, 0);
        rd(3'd5, v); chk("R11 svc ignored cause", v, stat_word(0, 1, 0));
        wr(3'd5, 16'd2);
        chk("R11 irq cleared", irq, 0);
        edges_until(2, 200, n); chk("R11 second period", n, exp_period(30) - 2);
        chk("R11 no fault", {nmi, srst}, 0);

        // R3, R7, R8, R9 with NMI action
        do_por();
        cfgw(3'd2, 16'd40);
        cfgw(3'd1, 16'd1);
        edges_until(0, 200, n); chk("R3 timeout edges", n, exp_period(40));
        chk("R7 nmi path no reset", srst, 0);
        rd(3'd5, v); chk("R6 timeout cause", v, stat_word(1, 0, 1));
        edges_until(1, 200, n); chk("R8 escalation edges", n, exp_period(40));
        chk("R8 nmi still held", nmi, 1);
        edges_until(3, 200, n); chk("R9 pulse length", n, 16);
        wr(3'd5, 16'd1);
        chk("R8 nmi acknowledged", nmi, 0);

        // R12 cause across warm reset
        rst = 1'b1; repeat (2) @(posedge clk); #1; rst = 1'b0;
        rd(3'd5, v); chk("R12 cause kept", v, stat_word(1, 0, 0));
        rd(3'd1, v); chk("R12 warm reset ctrl", v, 3);
        do_por();
        rd(3'd5, v); chk("R12 cold reset clears", v, 0);

        // R10 commit lock, then R6 bad key
        cfgw(3'd1, 16'd1);
        cfgw(3'd1, 16'd4);
        rd(3'd1, v); chk("R10 enable locked", v, 1);
        wr(3'd4, 16'h1234);
        chk("R6 bad key nmi", nmi, 1);
        rd(3'd5, v); chk("R6 bad key cause", v, stat_word(3, 0, 1));

        // R7, R9 with reset action
        do_por();
        cfgw(3'd2, 16'd20);
        cfgw(3'd1, 16'd3);
        edges_until(1, 200, n); chk("R7 reset action edges", n, exp_period(20));
        chk("R7 reset action no nmi", nmi, 0);
        edges_until(3, 200, n); chk("R9 pulse length reset action", n, 16);

        // R4, R5 random window trials
        for (int i = 0; i < 24; i++) begin
            int t, w, d;
            t = 24 + int'($urandom % 60);
            w = int'($urandom % t);
            d = int'($urandom % t);
            if (i == 0) begin w = 10; d = 10; end
            if (i == 1) begin w = 10; d = 9; end
            do_por();
            cfgw(3'd2, 16'(t));
            cfgw(3'd3, 16'(w));
            cfgw(3'd1, 16'd1);
            repeat (d) @(posedge clk);
            #1;
            rd(3'd6, v); chk("R4 count readback", v, d);
            wr(3'd4, 16'hA5A5);
            if (exp_early(d, w)) begin
                chk("R5 early kick nmi", nmi, 1);
                rd(3'd5, v); chk("R5 early cause", v, stat_word(2, 0, 1));
            end else begin
                chk("R4 valid kick no nmi", nmi, 0);
                rd(3'd6, v); chk("R4 valid kick reload", v, 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule